// File: doc/BRIEF.md
# External DMA Request/Acknowledge Handshake Controller

This block serves a single external DMA channel. A peripheral outside the chip pulls an active-low request line low. The line has no timing relation to the core clock, so it passes through a two-flop synchronizer first. Once the synchronized request is seen, the controller lowers its active-low acknowledge, raises a request for the system bus, and waits for the grant. It then performs one service on a simple memory-style master port: one read from a fixed source address and one write of that same word to a fixed destination address. When the write completes, the controller drops the bus request and releases the acknowledge in the same cycle. It then returns to idle.

A request that stays low after a service does not start a second one. The synchronized request must go inactive and then become active again first. Each bus strobe is held until the slave returns ready, so slow memories stretch the service without any extra logic.

Top module: `xdma_handshake`

## Requirements
- R1: While reset is high, and in the cycle after it, ack_n_o is 1 and bus_req_o, rd_o and wr_o are 0.
- R2: If req_n_i is sampled low at clock edge k, ack_n_o goes low after edge k+2 and not earlier. This is three edges, because two synchronizer stages come first.
- R3: bus_req_o rises one cycle after ack_n_o falls, and bus_req_o is never 1 while ack_n_o is 1.
- R4: rd_o rises only after an edge at which both bus_req_o and bus_gnt_i were 1. While rd_o is 1, addr_o equals SRC_ADDR.
- R5: wr_o rises in the cycle after the read completes (rd_o and mem_rdy_i both 1 at an edge). While wr_o is 1, addr_o equals DST_ADDR and wdata_o equals the rdata_i value taken at the read-completion edge.
- R6: At the edge where the write completes (wr_o and mem_rdy_i both 1), ack_n_o returns to 1, bus_req_o returns to 0 and wr_o returns to 0, all together.
- R7: ack_n_o stays low for at least three cycles per service. With an immediate grant and no wait states it is low for exactly 4 cycles. Each wait cycle on either strobe adds one cycle.
- R8: While the synchronized request stays active, no further service starts. A new service needs the request to be seen inactive and then active again.
- R9: Without a grant, the controller holds ack_n_o low and bus_req_o high and does not strobe. With mem_rdy_i low, the active strobe and its address are held.
- R10: rd_o and wr_o are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| req_n_i | input | 1 | Asynchronous DMA request from outside, active low |
| ack_n_o | output | 1 | DMA acknowledge to outside, active low |
| bus_req_o | output | 1 | System bus ownership request |
| bus_gnt_i | input | 1 | System bus grant |
| rd_o | output | 1 | Read strobe, held until mem_rdy_i |
| wr_o | output | 1 | Write strobe, held until mem_rdy_i |
| addr_o | output | ADDR_W | Address of the active strobe |
| wdata_o | output | DATA_W | Write data (the word captured by the read) |
| rdata_i | input | DATA_W | Read data, valid at the read-completion edge |
| mem_rdy_i | input | 1 | Slave ready; completes the active strobe at this edge |

## Verification
The assertions take several things for granted about the inputs:
- Once given, the grant stays high until bus_req_o drops.
- mem_rdy_i only matters while a strobe is active.
- rdata_i is valid at the edge where the read completes.
- req_n_i never changes near a clock edge, so its sampled value is well defined for the latency check.

The stimulus keeps within these limits. Every input is driven on the falling clock edge. The grant either copies bus_req_o or is held manually and released only between services. A slave model in the bench derives ready from a per-strobe wait counter and keeps the read data constant through each service.

// File: rtl/xdma_pkg.sv
package xdma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_BUSREQ = 2'd1,
        ST_READ   = 2'd2,
        ST_WRITE  = 2'd3
    } xdma_state_e;

    typedef struct packed {
        xdma_state_e state;
        logic        ack;
        logic        breq;
        logic        armed;
    } xdma_seq_t;

endpackage

// File: rtl/xdma_sync.sv
module xdma_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] stage_d, stage_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb stage_d = din;
        end else begin : g_chain
            always_comb stage_d = {stage_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) stage_q <= {STAGES{RST_VAL}};
        else     stage_q <= stage_d;
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/xdma_seq.sv
module xdma_seq
    import xdma_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_act,
    input  logic bus_gnt,
    input  logic mem_rdy,
    output logic ack,
    output logic breq,
    output logic rd,
    output logic wr,
    output logic capture
);

    xdma_seq_t seq_d, seq_q;

    always_comb begin
        seq_d   = seq_q;
        capture = 1'b0;

        // re-arm once the synchronized request has been seen inactive
        if (!req_act) seq_d.armed = 1'b1;

        unique case (seq_q.state)
            ST_IDLE: begin
                if (req_act && seq_q.armed) begin
                    seq_d.state = ST_BUSREQ;
                    seq_d.ack   = 1'b1;
                    seq_d.armed = 1'b0;
                end
            end
            ST_BUSREQ: begin
                seq_d.breq = 1'b1;
                if (seq_q.breq && bus_gnt) seq_d.state = ST_READ;
            end
            ST_READ: begin
                if (mem_rdy) begin
                    capture     = 1'b1;
                    seq_d.state = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (mem_rdy) begin
                    seq_d.state = ST_IDLE;
                    seq_d.ack   = 1'b0;
                    seq_d.breq  = 1'b0;
                end
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q.state <= ST_IDLE;
            seq_q.ack   <= 1'b0;
            seq_q.breq  <= 1'b0;
            seq_q.armed <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign ack  = seq_q.ack;
    assign breq = seq_q.breq;
    assign rd   = (seq_q.state == ST_READ);
    assign wr   = (seq_q.state == ST_WRITE);

endmodule

// File: rtl/xdma_datapath.sv
module xdma_datapath #(
    parameter int                ADDR_W   = 32,
    parameter int                DATA_W   = 32,
    parameter logic [ADDR_W-1:0] SRC_ADDR = '0,
    parameter logic [ADDR_W-1:0] DST_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic              rd,
    input  logic              wr,
    input  logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata
);

    logic [DATA_W-1:0] hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (capture) hold_d = rdata;
    end

    always_ff @(posedge clk) begin
        if (rst) hold_q <= '0;
        else     hold_q <= hold_d;
    end

    always_comb begin
        if (wr)      addr = DST_ADDR;
        else if (rd) addr = SRC_ADDR;
        else         addr = '0;
    end

    assign wdata = wr ? hold_q : '0;

endmodule

// File: rtl/xdma_handshake.sv
module xdma_handshake #(
    parameter int                ADDR_W      = 32,
    parameter int                DATA_W      = 32,
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] SRC_ADDR    = 32'h0000_1000,
    parameter logic [ADDR_W-1:0] DST_ADDR    = 32'h0000_2000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_n_i,
    output logic              ack_n_o,
    output logic              bus_req_o,
    input  logic              bus_gnt_i,
    output logic              rd_o,
    output logic              wr_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    input  logic [DATA_W-1:0] rdata_i,
    input  logic              mem_rdy_i
);

    logic req_n_sync;
    logic ack, capture;

    xdma_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (req_n_i),
        .dout (req_n_sync)
    );

    xdma_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .req_act (~req_n_sync),
        .bus_gnt (bus_gnt_i),
        .mem_rdy (mem_rdy_i),
        .ack     (ack),
        .breq    (bus_req_o),
        .rd      (rd_o),
        .wr      (wr_o),
        .capture (capture)
    );

    xdma_datapath #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .SRC_ADDR (SRC_ADDR),
        .DST_ADDR (DST_ADDR)
    ) u_dp (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .rd      (rd_o),
        .wr      (wr_o),
        .rdata   (rdata_i),
        .addr    (addr_o),
        .wdata   (wdata_o)
    );

    assign ack_n_o = ~ack;

endmodule

// File: rtl/xdma_handshake_chk.sv
module xdma_handshake_chk #(
    parameter int                ADDR_W   = 32,
    parameter int                DATA_W   = 32,
    parameter logic [ADDR_W-1:0] SRC_ADDR = '0,
    parameter logic [ADDR_W-1:0] DST_ADDR = '0
) (
    input logic              clk,
    input logic              rst,
    input logic              req_n_i,
    input logic              ack_n_o,
    input logic              bus_req_o,
    input logic              bus_gnt_i,
    input logic              rd_o,
    input logic              wr_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic [DATA_W-1:0] wdata_o,
    input logic [DATA_W-1:0] rdata_i,
    input logic              mem_rdy_i
);

    logic [2:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst)               low_cnt <= '0;
        else if (ack_n_o)      low_cnt <= '0;
        else if (low_cnt != 7) low_cnt <= low_cnt + 3'd1;
    end

    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (ack_n_o && !bus_req_o && !rd_o && !wr_o)); // R1
    AST_ACK_LATENCY: assert property (@(posedge clk) disable iff (rst) $fell(ack_n_o) |-> $past(!req_n_i, 3)); // R2
    AST_BREQ_UNDER_ACK: assert property (@(posedge clk) disable iff (rst) bus_req_o |-> !ack_n_o); // R3
    AST_BREQ_AFTER_ACK: assert property (@(posedge clk) disable iff (rst) $rose(bus_req_o) |-> $past(!ack_n_o)); // R3
    AST_RD_NEEDS_GNT: assert property (@(posedge clk) disable iff (rst) $rose(rd_o) |-> $past(bus_req_o && bus_gnt_i)); // R4
    AST_RD_ADDR: assert property (@(posedge clk) disable iff (rst) rd_o |-> addr_o == SRC_ADDR); // R4
    AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (rst) $rose(wr_o) |-> $past(rd_o && mem_rdy_i)); // R5
    AST_WR_ADDR: assert property (@(posedge clk) disable iff (rst) wr_o |-> addr_o == DST_ADDR); // R5
    AST_WR_DATA: assert property (@(posedge clk) disable iff (rst) $rose(wr_o) |-> wdata_o == $past(rdata_i)); // R5
    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (rst) $rose(ack_n_o) |-> (!bus_req_o && !wr_o && $past(wr_o && mem_rdy_i))); // R6
    AST_ACK_MIN_LEN: assert property (@(posedge clk) disable iff (rst) $rose(ack_n_o) |-> low_cnt >= 3'd3); // R7
    AST_HOLD_NO_GNT: assert property (@(posedge clk) disable iff (rst) (bus_req_o && !rd_o && !wr_o && !bus_gnt_i) |=> !rd_o); // R9
    AST_STROBE_HOLD: assert property (@(posedge clk) disable iff (rst) (rd_o && !mem_rdy_i) |=> (rd_o && $stable(addr_o))); // R9
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst) $onehot0({rd_o, wr_o})); // R10

endmodule

bind xdma_handshake xdma_handshake_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .SRC_ADDR (SRC_ADDR),
    .DST_ADDR (DST_ADDR)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_n_i   (req_n_i),
    .ack_n_o   (ack_n_o),
    .bus_req_o (bus_req_o),
    .bus_gnt_i (bus_gnt_i),
    .rd_o      (rd_o),
    .wr_o      (wr_o),
    .addr_o    (addr_o),
    .wdata_o   (wdata_o),
    .rdata_i   (rdata_i),
    .mem_rdy_i (mem_rdy_i)
);

// File: tb/sim_xdma_handshake.sv
module sim_xdma_handshake;

    localparam int          CLK_PERIOD = 10;
    localparam int          AW  = 32;
    localparam int          DW  = 32;
    localparam logic [31:0] SRC = 32'h0000_1000;
    localparam logic [31:0] DST = 32'h0000_2000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_n = 1'b1;
    logic          ack_n_o, bus_req_o, rd_o, wr_o;
    logic [AW-1:0] addr_o;
    logic [DW-1:0] wdata_o;
    logic          bus_gnt, mem_rdy;
    logic [DW-1:0] slv_data = 32'hA5A5_0001;

    int  n_chk = 0, n_bad = 0;
    int  slv_wait = 0, wcnt = 0;
    logic [1:0] prev_kind = 2'b00;
    int  rd_cnt = 0, wr_cnt = 0, run = 0, last_run = 0, overlap = 0;
    logic [AW-1:0] rd_addr = '0, wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic gnt_auto = 1'b1, gnt_auto_q = 1'b0, gnt_man = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign bus_gnt = gnt_auto ? gnt_auto_q : gnt_man;
    assign mem_rdy = (rd_o || wr_o) && (wcnt == slv_wait);

    xdma_handshake #(
        .ADDR_W (AW), .DATA_W (DW), .SYNC_STAGES (2),
        .SRC_ADDR (SRC), .DST_ADDR (DST)
    ) u0 (
        .clk (clk), .rst (rst), .req_n_i (req_n), .ack_n_o (ack_n_o),
        .bus_req_o (bus_req_o), .bus_gnt_i (bus_gnt), .rd_o (rd_o), .wr_o (wr_o),
        .addr_o (addr_o), .wdata_o (wdata_o), .rdata_i (slv_data), .mem_rdy_i (mem_rdy)
    );

    // slave model and observers, all on the falling edge
    always @(negedge clk) begin
        if (rst) begin
            wcnt = 0; prev_kind = 2'b00; run = 0; gnt_auto_q = 1'b0;
        end else begin
            if ({rd_o, wr_o} != prev_kind) wcnt = 0;
            else if (wcnt < 15)            wcnt = wcnt + 1;
            prev_kind = {rd_o, wr_o};
            if (rd_o && wcnt == slv_wait) begin rd_cnt++; rd_addr = addr_o; end
            if (wr_o && wcnt == slv_wait) begin wr_cnt++; wr_addr = addr_o; wr_data = wdata_o; end
            if (!ack_n_o) run++;
            else begin
                if (run != 0) last_run = run;
                run = 0;
            end
            if (rd_o && wr_o) overlap++;
            gnt_auto_q = bus_req_o;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic wait_wr(input int target, input string tag);
        int n = 0;
        while (wr_cnt < target && n < 200) begin @(negedge clk); n++; end
        chk(tag, 64'(wr_cnt >= target), 64'd1);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 in reset", {ack_n_o, bus_req_o, rd_o, wr_o}, 4'b1000);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset", {ack_n_o, bus_req_o, rd_o, wr_o}, 4'b1000);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_basic();
        slv_data = 32'hA5A5_0001;
        @(negedge clk); req_n = 1'b0;
        @(negedge clk); chk("R2 not yet 1", ack_n_o, 1);
        @(negedge clk); chk("R2 not yet 2", ack_n_o, 1);
        @(negedge clk); chk("R2 ack low", ack_n_o, 0);
        chk("R3 breq after ack", bus_req_o, 0);
        @(negedge clk); chk("R3 breq high", bus_req_o, 1);
        chk("R4 no read yet", rd_o, 0);
        @(negedge clk); chk("R4 read", rd_o, 1);
        chk("R4 src addr", addr_o, SRC);
        @(negedge clk); chk("R5 write", wr_o, 1);
        chk("R5 dst addr", addr_o, DST);
        chk("R5 wdata", wdata_o, 32'hA5A5_0001);
        chk("R6 held during write", {ack_n_o, bus_req_o}, 2'b01);
        @(negedge clk); chk("R6 release", {ack_n_o, bus_req_o, wr_o}, 3'b100);
        @(negedge clk); chk("R7 ack length", last_run, 4);
        req_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_held();
        int base = wr_cnt;
        int lows = 0;
        @(negedge clk); req_n = 1'b0;
        wait_wr(base + 1, "R8 first service");
        repeat (4) @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!ack_n_o) lows++;
        end
        chk("R8 no retrigger ack", lows, 0);
        chk("R8 no retrigger writes", wr_cnt, base + 1);
        req_n = 1'b1;
        repeat (4) @(negedge clk);
        req_n = 1'b0;
        wait_wr(base + 2, "R8 re-armed service");
        repeat (4) @(negedge clk);
        req_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_no_grant();
        int base = rd_cnt;
        int bad = 0;
        gnt_man = 1'b0; gnt_auto = 1'b0;
        @(negedge clk); req_n = 1'b0;
        repeat (6) @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (!(ack_n_o == 0 && bus_req_o == 1 && rd_o == 0)) bad++;
        end
        chk("R9 wait for grant", bad, 0);
        chk("R9 no read without grant", rd_cnt, base);
        gnt_man = 1'b1;
        wait_wr(wr_cnt + 1, "R9 service after grant");
        chk("R9 read addr", rd_addr, SRC);
        repeat (4) @(negedge clk);
        gnt_auto = 1'b1; gnt_man = 1'b0;
        req_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_wait_states();
        slv_wait = 3;
        slv_data = 32'h3C3C_7E01;
        @(negedge clk); req_n = 1'b0;
        wait_wr(wr_cnt + 1, "R9 slow service");
        chk("R5 slow wdata", wr_data, 32'h3C3C_7E01);
        chk("R5 slow waddr", wr_addr, DST);
        repeat (4) @(negedge clk);
        chk("R7 stretched ack", last_run, 10);
        req_n = 1'b1;
        slv_wait = 0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_held();
        t_no_grant();
        t_wait_states();
        chk("R10 strobe overlap", overlap, 0);
        summary();
        $finish;
    end

endmodule